// File: doc/BRIEF.md
# Dual-Pipe Floating-Point Issue Timing Scoreboard

This block decides, cycle by cycle, when in-order floating-point micro-ops may leave the issue stage of a back end with two execution pipes. Two micro-ops are offered each cycle. Slot 0 is the older one. Each micro-op carries a 4-bit class code, a destination tag, up to two source tags with their own valid bits, and a flag that turns off local forwarding for its result. Real arithmetic is not performed. Only the timing is modelled.

The block keeps one entry per register tag. Each entry holds a countdown until the tag's result is available, plus the forwarding cluster that produced it. The clusters are floating-point, integer and store/convert. A consumer in the producer's cluster sees the result after the base latency. A consumer in another cluster sees it one cycle later. A producer with local forwarding disabled also costs that extra cycle inside its own cluster. The multiply unit does not accept a new operation on every cycle for the double and extended widths, and the block enforces that spacing. The upstream stage keeps presenting the same micro-ops until they issue. It then removes as many as were issued.

Top module: `fp_issue_sb`

## Requirements
- R1: After reset every tag counts as available with no producing cluster. A micro-op whose sources are all untouched tags issues in the first cycle it is offered. With no valid input, neither slot issues and stall is low.
- R2: Class codes map to pipes and latencies as follows:
  - 0 = SIMD ALU: latency 1, either pipe.
  - 1 = FP logical: latency 1, either pipe.
  - 2 = SIMD integer multiply: latency 2, pipe 0.
  - 3 = single-precision multiply: latency 2, pipe 1.
  - 4 = FP add: latency 3, pipe 0.
  - 5 = store/convert: latency 3, pipe 1.
  - 6 = double-precision multiply: latency 4, pipe 1.
  - 7 = extended multiply: latency 5, pipe 1.
  - 8 to 15 behave as code 0.
  - issuePipe bit value 0 means pipe 0.
- R3: A consumer in the same cluster as its producer, with forwarding enabled on the producer, may issue exactly L cycles after the producer issued, where L is the producer's latency. It may not issue earlier.
- R4: Codes 0, 2 and 8 to 15 belong to the integer cluster. Codes 1, 3, 4, 6 and 7 belong to the floating-point cluster. Code 5 belongs to the store/convert cluster. A consumer in a different cluster from its producer may issue no earlier than L+1 cycles after the producer.
- R5: A producer issued with its no-local-forwarding flag set delays every consumer to L+1 cycles, including consumers in its own cluster.
- R6: Classes 3, 6 and 7 use the multiply unit. After class 6 issues, the next multiply-unit op may issue no earlier than 2 cycles later. After class 7, no earlier than 3 cycles later. After class 3, the next cycle is allowed. Other pipe-1 classes are never held back by this spacing.
- R7: At most one micro-op issues per pipe per cycle. An either-pipe micro-op takes pipe 0 when pipe 0 is free in that cycle, otherwise pipe 1.
- R8: Slot 1 issues only in a cycle where slot 0 issues. Slot 1 never issues when one of its valid sources equals slot 0's destination.
- R9: stall is high exactly when slot 0 is valid and does not issue.
- R10: A source whose valid bit is low has no effect on readiness.
- R11: The most recent issue to a tag replaces its entry. When both slots issue to the same tag in one cycle, slot 1's timing is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 2 | Per-slot micro-op valid; slot 0 is older |
| opClass | input | 2x4 | Per-slot class code |
| opDst | input | 2xTAG_W | Per-slot destination tag |
| opSrc | input | 2x2xTAG_W | Per-slot source tags |
| opSrcValid | input | 2x2 | Per-slot source valid bits |
| opNoLocalFwd | input | 2 | Per-slot local-forwarding-disabled flag |
| issueValid | output | 2 | Per-slot issue in this cycle |
| issuePipe | output | 2 | Per-slot pipe chosen (0 or 1) |
| stall | output | 1 | Slot 0 is valid but held |

## Verification
The hardest situations to reach from the ports are the ones where several timing rules meet on a single cycle. Examples are a cross-cluster consumer whose extra cycle lands just as the multiply unit frees up, or a slot-1 either-pipe op that must fall back to pipe 1 while another op writes the same tag. A directed opening covers each rule in isolation. After it comes a long random run over only six tags, so that most micro-ops depend on recent producers. Its class mix is weighted toward multiplies, and forwarding-disabled flags and idle gaps are scattered through it. A cycle-count reference model in the bench predicts the issue decision of every cycle.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  localparam int CLS_W   = 4;
  localparam int LAT_W   = 3;
  localparam int MAX_LAT = 5;

  typedef enum logic [1:0] {CL_NONE = 2'd0, CL_FP = 2'd1, CL_INT = 2'd2, CL_STC = 2'd3} cluster_e;
  typedef enum logic [1:0] {PK_ANY = 2'd0, PK_P0 = 2'd1, PK_P1 = 2'd2} pipeKind_e;

  typedef struct packed {
    logic [LAT_W-1:0] lat;
    cluster_e         clu;
    pipeKind_e        kind;
    logic             isFpm;
    logic [1:0]       fpmHold;
  } classInfo_t;

  // control -> table strobes
  typedef struct packed {
    logic [1:0]            wrEn;
    logic [1:0]            wrLfd;
    logic [1:0][LAT_W-1:0] wrLat;
    logic [1:0][1:0]       wrClu;
  } sbStrobe_t;

  function automatic classInfo_t decodeClass(input logic [CLS_W-1:0] cls);
    classInfo_t ci;
    ci.lat = LAT_W'(1); ci.clu = CL_INT; ci.kind = PK_ANY; ci.isFpm = 1'b0; ci.fpmHold = 2'd0;
    case (cls)
      4'd1: ci.clu = CL_FP;
      4'd2: begin ci.lat = LAT_W'(2); ci.kind = PK_P0; end
      4'd3: begin ci.lat = LAT_W'(2); ci.clu = CL_FP; ci.kind = PK_P1; ci.isFpm = 1'b1; end
      4'd4: begin ci.lat = LAT_W'(3); ci.clu = CL_FP; ci.kind = PK_P0; end
      4'd5: begin ci.lat = LAT_W'(3); ci.clu = CL_STC; ci.kind = PK_P1; end
      4'd6: begin ci.lat = LAT_W'(4); ci.clu = CL_FP; ci.kind = PK_P1; ci.isFpm = 1'b1; ci.fpmHold = 2'd1; end
      4'd7: begin ci.lat = LAT_W'(5); ci.clu = CL_FP; ci.kind = PK_P1; ci.isFpm = 1'b1; ci.fpmHold = 2'd2; end
      default: ;
    endcase
    return ci;
  endfunction
endpackage

// File: rtl/fpsb_table.sv
module fpsb_table
  import fpsb_pkg::*;
#(
  parameter int NUM_TAGS = 16,
  parameter int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  sbStrobe_t                        strobe,
  input  logic [1:0][TAG_W-1:0]            dstTag,
  input  logic [1:0][1:0][TAG_W-1:0]       srcTag,
  input  logic [1:0][1:0]                  srcVld,
  input  logic [1:0][1:0]                  consClu,
  output logic [1:0]                       srcRdy
);
  logic [LAT_W-1:0] cnt    [NUM_TAGS];
  logic [1:0]       prodClu[NUM_TAGS];
  logic             noFwd  [NUM_TAGS];
  logic [NUM_TAGS-1:0] hit0, hit1;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : gEntry
    assign hit0[g] = strobe.wrEn[0] && (dstTag[0] == TAG_W'(g));
    assign hit1[g] = strobe.wrEn[1] && (dstTag[1] == TAG_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt[g]     <= '0;
        prodClu[g] <= CL_NONE;
        noFwd[g]   <= 1'b0;
      end else if (hit1[g]) begin
        cnt[g]     <= strobe.wrLat[1];
        prodClu[g] <= strobe.wrClu[1];
        noFwd[g]   <= strobe.wrLfd[1];
      end else if (hit0[g]) begin
        cnt[g]     <= strobe.wrLat[0];
        prodClu[g] <= strobe.wrClu[0];
        noFwd[g]   <= strobe.wrLfd[0];
      end else if (cnt[g] != '0) begin
        cnt[g]     <= cnt[g] - 1'b1;
      end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] <= LAT_W'(MAX_LAT));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] != '0 && !hit0[g] && !hit1[g]) |=> (cnt[g] == $past(cnt[g]) - 1'b1));
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      srcRdy[s] = 1'b1;
      for (int k = 0; k < 2; k++) begin
        logic [LAT_W-1:0] c;
        logic             extra;
        c     = cnt[srcTag[s][k]];
        extra = (prodClu[srcTag[s][k]] != consClu[s]) || noFwd[srcTag[s][k]];
        if (srcVld[s][k] && !((c == '0) || (c == LAT_W'(1) && !extra)))
          srcRdy[s] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpsb_ctrl.sv
module fpsb_ctrl
  import fpsb_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 slotVld,
  input  logic [1:0][CLS_W-1:0]      slotCls,
  input  logic [1:0][TAG_W-1:0]      dstTag,
  input  logic [1:0][1:0][TAG_W-1:0] srcTag,
  input  logic [1:0][1:0]            srcVld,
  input  logic [1:0]                 noLocalFwd,
  input  logic [1:0]                 srcRdy,
  output logic [1:0][1:0]            consClu,
  output sbStrobe_t                  strobe,
  output logic [1:0]                 issue,
  output logic [1:0]                 pipeSel,
  output logic                       stall
);
  classInfo_t ci0, ci1;
  logic [1:0] fpmBusy;
  logic       fpmFree, fit0, fit1, pipe0Used, pipe1Used, dep1;
  logic       fpmStart;
  logic [1:0] fpmHoldNext;

  always_comb begin
    ci0 = decodeClass(slotCls[0]);
    ci1 = decodeClass(slotCls[1]);
    consClu[0] = ci0.clu;
    consClu[1] = ci1.clu;
    fpmFree = (fpmBusy == 2'd0);

    fit0 = 1'b1; pipeSel[0] = 1'b0;
    if (ci0.kind == PK_P1) begin
      pipeSel[0] = 1'b1;
      fit0 = !ci0.isFpm || fpmFree;
    end
    issue[0]  = slotVld[0] && srcRdy[0] && fit0;
    pipe0Used = issue[0] && !pipeSel[0];
    pipe1Used = issue[0] &&  pipeSel[0];

    dep1 = (srcVld[1][0] && srcTag[1][0] == dstTag[0]) ||
           (srcVld[1][1] && srcTag[1][1] == dstTag[0]);

    pipeSel[1] = 1'b0; fit1 = 1'b0;
    case (ci1.kind)
      PK_P0: fit1 = !pipe0Used;
      PK_P1: begin pipeSel[1] = 1'b1; fit1 = !pipe1Used && (!ci1.isFpm || fpmFree); end
      default: begin
        if (!pipe0Used) fit1 = 1'b1;
        else begin pipeSel[1] = 1'b1; fit1 = !pipe1Used; end
      end
    endcase
    issue[1] = issue[0] && slotVld[1] && srcRdy[1] && !dep1 && fit1;
    stall    = slotVld[0] && !issue[0];

    strobe.wrEn     = issue;
    strobe.wrLfd    = noLocalFwd;
    strobe.wrLat[0] = ci0.lat;
    strobe.wrLat[1] = ci1.lat;
    strobe.wrClu[0] = ci0.clu;
    strobe.wrClu[1] = ci1.clu;

    fpmStart    = (issue[0] && ci0.isFpm) || (issue[1] && ci1.isFpm);
    fpmHoldNext = (issue[0] && ci0.isFpm) ? ci0.fpmHold : ci1.fpmHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                fpmBusy <= 2'd0;
    else if (fpmStart)        fpmBusy <= fpmHoldNext;
    else if (fpmBusy != 2'd0) fpmBusy <= fpmBusy - 2'd1;
  end

  // R7
  pipe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issue[0] && issue[1]) |-> (pipeSel[0] != pipeSel[1]));
  // R8
  in_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue[1] |-> issue[0]);
  // R8
  same_cycle_dep_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue[1] |-> !((srcVld[1][0] && srcTag[1][0] == dstTag[0]) ||
                   (srcVld[1][1] && srcTag[1][1] == dstTag[0])));
  // R6
  xmul_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issue[0] && slotCls[0] == 4'd7) |=> !((issue[0] && ci0.isFpm) || (issue[1] && ci1.isFpm)));
  // R2
  fixed_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issue[0] && (slotCls[0] == 4'd2 || slotCls[0] == 4'd4)) |-> !pipeSel[0]);
  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (issue == 2'b00));
endmodule

// File: rtl/fp_issue_sb.sv
module fp_issue_sb
  import fpsb_pkg::*;
#(
  parameter int NUM_TAGS = 16,
  parameter int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 opValid,
  input  logic [1:0][3:0]            opClass,
  input  logic [1:0][TAG_W-1:0]      opDst,
  input  logic [1:0][1:0][TAG_W-1:0] opSrc,
  input  logic [1:0][1:0]            opSrcValid,
  input  logic [1:0]                 opNoLocalFwd,
  output logic [1:0]                 issueValid,
  output logic [1:0]                 issuePipe,
  output logic                       stall
);
  sbStrobe_t       strobe;
  logic [1:0]      srcRdy;
  logic [1:0][1:0] consClu;

  fpsb_table #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) uTable (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dstTag(opDst),
    .srcTag(opSrc), .srcVld(opSrcValid), .consClu(consClu), .srcRdy(srcRdy)
  );

  fpsb_ctrl #(.TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .slotVld(opValid), .slotCls(opClass),
    .dstTag(opDst), .srcTag(opSrc), .srcVld(opSrcValid),
    .noLocalFwd(opNoLocalFwd), .srcRdy(srcRdy), .consClu(consClu),
    .strobe(strobe), .issue(issueValid), .pipeSel(issuePipe), .stall(stall)
  );
endmodule

// File: tb/sim_fp_issue_sb.sv
module sim_fp_issue_sb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]            opValid = '0;
  logic [1:0][3:0]       opClass = '0;
  logic [1:0][3:0]       opDst = '0;
  logic [1:0][1:0][3:0]  opSrc = '0;
  logic [1:0][1:0]       opSrcValid = '0;
  logic [1:0]            opNoLocalFwd = '0;
  logic [1:0]            issueValid, issuePipe;
  logic                  stall;

  always #2 clk = ~clk;

  fp_issue_sb u0 (.*);

  typedef struct {
    int cls; int dst; int s0; int s1; bit v0; bit v1; bit lfd; bit bubble;
  } op_t;
  typedef struct packed { logic [1:0] iv; logic [1:0] ps; logic st; } exp_t;

  op_t   pend[$];
  string pendLbl[$];
  exp_t  expQ[$];
  string expLbl[$];
  int checks = 0, errors = 0, cyc = 0;
  int avail[16]; int rclu[16]; bit rlfd[16]; int fpmFree = 0;
  bit done = 0;

  function automatic int bLat(int c);
    case (c) 2, 3: return 2; 4, 5: return 3; 6: return 4; 7: return 5; default: return 1; endcase
  endfunction
  function automatic int bClu(int c);
    case (c) 1, 3, 4, 6, 7: return 1; 5: return 3; default: return 2; endcase
  endfunction
  function automatic int bPipe(int c);
    case (c) 2, 4: return 0; 3, 5, 6, 7: return 1; default: return -1; endcase
  endfunction
  function automatic bit bFpm(int c); return c == 3 || c == 6 || c == 7; endfunction
  function automatic int bGap(int c); return c == 6 ? 2 : (c == 7 ? 3 : 1); endfunction

  function automatic bit srcOk(int tag, bit v, int cons);
    int ex;
    if (!v) return 1;
    ex = (rclu[tag] != 0 && (rclu[tag] != cons || rlfd[tag])) ? 1 : 0;
    return cyc >= avail[tag] + ex;
  endfunction
  function automatic bit rdy(op_t o);
    return srcOk(o.s0, o.v0, bClu(o.cls)) && srcOk(o.s1, o.v1, bClu(o.cls));
  endfunction

  task automatic addOp(int cls, int dst, int s0, bit v0, int s1, bit v1, bit lfd, string lbl);
    op_t o;
    o.cls = cls; o.dst = dst; o.s0 = s0; o.s1 = s1; o.v0 = v0; o.v1 = v1; o.lfd = lfd; o.bubble = 0;
    pend.push_back(o); pendLbl.push_back(lbl);
  endtask
  task automatic addIdle(int n, string lbl);
    op_t o;
    o.cls = 0; o.dst = 0; o.s0 = 0; o.s1 = 0; o.v0 = 0; o.v1 = 0; o.lfd = 0; o.bubble = 1;
    for (int i = 0; i < n; i++) begin pend.push_back(o); pendLbl.push_back(lbl); end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e; string l;
        e = expQ.pop_front(); l = expLbl.pop_front();
        checks++;
        if (issueValid !== e.iv || (issuePipe & issueValid) !== (e.ps & e.iv) || stall !== e.st) begin
          errors++;
          $display("FAIL %s cyc %0d: got iv=%b pipe=%b stall=%b exp iv=%b pipe=%b stall=%b",
                   l, cyc, issueValid, issuePipe & issueValid, stall, e.iv, e.ps & e.iv, e.st);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver
  initial begin
    for (int t = 0; t < 16; t++) begin avail[t] = 0; rclu[t] = 0; rlfd[t] = 0; end
    // directed
    addIdle(3, "R1 idle after reset");
    addOp(4, 1, 9, 1, 10, 1, 0, "R1 fresh sources issue at once");
    addOp(4, 2, 1, 1, 0, 0, 0, "R3 fadd chain same cluster");
    addIdle(6, "R1 idle");
    addOp(0, 3, 0, 0, 0, 0, 0, "R4 alu producer");
    addOp(5, 4, 3, 1, 0, 0, 0, "R4 int to stc extra cycle");
    addOp(2, 5, 0, 0, 0, 0, 0, "R3 imul producer");
    addOp(0, 6, 5, 1, 0, 0, 0, "R3 imul to alu same cluster");
    addOp(0, 7, 0, 0, 0, 0, 1, "R5 no-local-fwd producer");
    addOp(0, 8, 7, 1, 0, 0, 0, "R5 same cluster delayed");
    addIdle(6, "R1 idle");
    addOp(6, 9, 0, 0, 0, 0, 0, "R6 dp mul");
    addOp(6, 10, 0, 0, 0, 0, 0, "R6 dp mul spacing");
    addOp(5, 12, 0, 0, 0, 0, 0, "R6 stc not held");
    addOp(3, 11, 0, 0, 0, 0, 0, "R6 sp mul after dp");
    addOp(7, 13, 0, 0, 0, 0, 0, "R6 xmul");
    addOp(7, 14, 0, 0, 0, 0, 0, "R6 xmul spacing");
    addOp(3, 15, 0, 0, 0, 0, 0, "R6 sp mul back to back");
    addOp(3, 15, 0, 0, 0, 0, 0, "R6 sp mul back to back");
    addIdle(6, "R1 idle");
    addOp(0, 1, 0, 0, 0, 0, 0, "R7 dual alu");
    addOp(1, 2, 0, 0, 0, 0, 0, "R7 dual alu second");
    addOp(4, 3, 0, 0, 0, 0, 0, "R7 fadd takes pipe0");
    addOp(0, 4, 0, 0, 0, 0, 0, "R7 alu falls to pipe1");
    addOp(5, 5, 0, 0, 0, 0, 0, "R7 stc takes pipe1");
    addOp(1, 6, 0, 0, 0, 0, 0, "R7 logic takes pipe0");
    addOp(0, 7, 0, 0, 0, 0, 0, "R8 producer");
    addOp(0, 8, 7, 1, 0, 0, 0, "R8 slot1 depends on slot0");
    addOp(4, 9, 0, 0, 0, 0, 0, "R8 fadd");
    addOp(2, 10, 0, 0, 0, 0, 0, "R8 imul pipe0 conflict");
    addIdle(6, "R1 idle");
    addOp(4, 11, 0, 0, 0, 0, 0, "R9 producer");
    addOp(0, 12, 11, 1, 0, 0, 0, "R9 stall while waiting");
    addIdle(6, "R1 idle");
    addOp(4, 13, 0, 0, 0, 0, 0, "R10 busy producer");
    addOp(0, 14, 13, 0, 13, 0, 0, "R10 invalid sources ignored");
    addOp(9, 1, 0, 0, 0, 0, 0, "R2 code 9 as alu");
    addOp(12, 2, 0, 0, 0, 0, 0, "R2 code 12 as alu");
    addIdle(6, "R1 idle");
    addOp(2, 2, 0, 0, 0, 0, 0, "R11 imul to tag2");
    addOp(0, 2, 0, 0, 0, 0, 0, "R11 alu to tag2 same cycle");
    addOp(0, 3, 2, 1, 0, 0, 0, "R11 consumer sees slot1 timing");
    // random
    for (int i = 0; i < 1500; i++) begin
      int r, c;
      r = $urandom_range(0, 99);
      if (r < 8) addIdle(1, "R4 random idle");
      else begin
        r = $urandom_range(0, 19);
        c = (r < 8) ? $urandom_range(0, 7) : (r < 12 ? $urandom_range(3, 7) : $urandom_range(0, 15));
        addOp(c, $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 1) == 1,
              $urandom_range(0, 5), $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0,
              "R4 random dependent stream");
      end
    end

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    while (pend.size() > 0) begin
      exp_t e; bit has0, has1, ok0, ok1, p0u, p1u; int k0, k1; bit pp0, pp1;
      e = '0;
      has0 = !pend[0].bubble;
      has1 = has0 && pend.size() > 1 && !pend[1].bubble;
      opValid = {has1, has0};
      for (int s = 0; s < 2; s++) begin
        if (s < pend.size()) begin
          opClass[s] = 4'(pend[s].cls); opDst[s] = 4'(pend[s].dst);
          opSrc[s][0] = 4'(pend[s].s0); opSrc[s][1] = 4'(pend[s].s1);
          opSrcValid[s] = {pend[s].v1, pend[s].v0}; opNoLocalFwd[s] = pend[s].lfd;
        end
      end
      ok0 = 0; ok1 = 0; pp0 = 0; pp1 = 0;
      if (has0) begin
        k0 = bPipe(pend[0].cls);
        pp0 = (k0 == 1);
        ok0 = rdy(pend[0]) && (k0 != 1 || !bFpm(pend[0].cls) || cyc >= fpmFree);
      end
      p0u = ok0 && !pp0; p1u = ok0 && pp0;
      if (ok0 && has1) begin
        bit dep, fit;
        k1 = bPipe(pend[1].cls);
        dep = (pend[1].v0 && pend[1].s0 == pend[0].dst) || (pend[1].v1 && pend[1].s1 == pend[0].dst);
        if (k1 == 0) fit = !p0u;
        else if (k1 == 1) begin pp1 = 1; fit = !p1u && (!bFpm(pend[1].cls) || cyc >= fpmFree); end
        else if (!p0u) fit = 1;
        else begin pp1 = 1; fit = !p1u; end
        ok1 = rdy(pend[1]) && !dep && fit;
      end
      e.iv = {ok1, ok0}; e.ps = {pp1, pp0}; e.st = has0 && !ok0;
      expQ.push_back(e); expLbl.push_back(pendLbl[0]);

      @(posedge clk); #1;
      for (int s = 0; s < 2; s++) begin
        if (e.iv[s]) begin
          avail[pend[s].dst] = cyc + bLat(pend[s].cls);
          rclu[pend[s].dst] = bClu(pend[s].cls);
          rlfd[pend[s].dst] = pend[s].lfd;
          if (bFpm(pend[s].cls)) fpmFree = cyc + bGap(pend[s].cls);
        end
      end
      if (!has0) begin void'(pend.pop_front()); void'(pendLbl.pop_front()); end
      else for (int s = 0; s < 2; s++)
        if (e.iv[s]) begin void'(pend.pop_front()); void'(pendLbl.pop_front()); end
      cyc++;
    end
    opValid = '0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule